// File: doc/BRIEF.md
# Biphase-Mark Subframe Receiver

This block takes a single serial line carrying biphase-mark coded audio subframes. The line is oversampled by the system clock. The caller supplies a divisor that gives the number of system clocks in one half-bit timeslot. The receiver waits idle for the falling edge that ends the three leading high slots of a preamble. It then times the centre of every following slot and gathers the whole 64-slot subframe. From the gathered slots it rebuilds the 32-bit subframe word.

The word is checked in two ways. Its preamble is compared with the one expected at the current position inside a 384-subframe block. Its parity is checked over the payload. When the word's invalid flag is clear, the 24-bit audio field is emitted with a one-clock strobe, truncated to a selectable width of 16, 20 or 24 bits. A preamble mismatch or a parity mismatch each raises a one-clock flag. Neither one stalls the receiver, so later subframes are decoded normally.

Top module: `bmc_subframe_rx`

## Requirements
- R1: While `rst` is high, the line is ignored and all outputs are 0. After `rst` falls, the block position is 0 and no partial capture survives, so the next subframe with preamble 0x17 is accepted without error.
- R2: A capture starts at clock edge E, the first edge that samples the line low after an edge that sampled it high while idle. Slot 3 is taken as low and slots 0 to 2 as high, so the low four slots equal 0x7 with the earliest slot in bit 0. Slot k (4..63) is sampled at edge E + div/2 + (k-3)*div, where div/2 rounds down. The results of that subframe are registered at the edge that samples slot 63.
- R3: Data bit i (0..31) is 1 when slots 2i and 2i+1 differ and 0 when they are equal. Bits 27:4 hold the audio sample with bit 4 as its LSB. Bit 28 is the invalid flag (1 = not valid). Bit 31 is parity.
- R4: `sample_stb_o` is high for exactly one clock per subframe whose invalid flag is 0. No strobe is given when the flag is 1, and `sample_o` keeps its last value between strobes.
- R5: `width_sel` 0 outputs the top 16 bits of the audio field (field >> 8). `width_sel` 1 outputs the top 20 bits (field >> 4). `width_sel` 2 or 3 outputs all 24 bits. The result is always right-aligned.
- R6: A position counter runs from 0 to 383 and then wraps. Position 0 expects preamble byte 0x17, odd positions expect 0x27 and the other even positions expect 0x47, earliest slot in bit 0. A mismatch gives a one-clock `pre_err_o` pulse, registered together with the subframe's results.
- R7: Parity is even. When bit 31 differs from the XOR of bits 4 to 30, `par_err_o` pulses for one clock, registered together with the subframe's results.
- R8: Errors do not suppress decoding. A subframe with a bad preamble or bad parity still strobes its sample if valid, and the next subframe decodes and advances the position normally.
- R9: Any divisor of 4 or more works. Divisors 4, 5 and 8 each yield correct samples with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the line |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Biphase-mark serial line |
| slot_div | input | DIV_W | System clocks per half-bit timeslot (4 or more) |
| width_sel | input | 2 | Output width: 0 = 16, 1 = 20, 2/3 = 24 bits |
| sample_o | output | 24 | Truncated, right-aligned audio sample |
| sample_stb_o | output | 1 | One-clock strobe for a valid sample |
| pre_err_o | output | 1 | One-clock pulse on a preamble mismatch |
| par_err_o | output | 1 | One-clock pulse on a parity mismatch |

## Verification
All results of a subframe land in one clock: the edge E + div/2 + 60*div, counted from the edge that first sees the falling line. They are visible from the falling clock edge that follows. The bench records the cycle count at the moment it drives slot 3 low. It then compares the cycle in which its monitor saw the strobe with that count plus 1 + div/2 + 60*div, for divisors 4, 5 and 8. Strobe, preamble and parity events are tallied at falling edges. The tallies are read only after one idle half-cycle beyond the end of the last slot, so each subframe's due result has already been latched when it is checked.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;
    localparam int SLOTS     = 64;
    localparam int BITS      = 32;
    localparam int AUD_W     = 24;
    localparam int AUD_LSB   = 4;
    localparam int INV_BIT   = 28;
    localparam int PAR_BIT   = 31;
    localparam int BLOCK_LEN = 384;
    localparam int POS_W     = $clog2(BLOCK_LEN);
    localparam int HELD_W    = SLOTS - 5;

    localparam logic [7:0] PRE_BLOCK = 8'h17;
    localparam logic [7:0] PRE_ODD   = 8'h27;
    localparam logic [7:0] PRE_EVEN  = 8'h47;
    localparam logic [3:0] LEAD_SLOTS = 4'h7;

    typedef enum logic {RX_IDLE, RX_CAPTURE} rx_state_e;
endpackage

// File: rtl/bmc_slot_timer.sv
module bmc_slot_timer
    import bmc_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic [DIV_W-1:0] slot_div,
    output logic             take_o,
    output logic             last_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [DIV_W:0] CNT_ONE = 1;

    typedef struct packed {
        rx_state_e         state;
        logic [DIV_W:0]    wait_cnt;
        logic [SLOT_W-1:0] slot;
        logic              line_prev;
    } tmr_t;

    localparam tmr_t TMR_RST = '{state: RX_IDLE, wait_cnt: '0, slot: '0, line_prev: 1'b0};

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d           = tmr_q;
        take_o          = 1'b0;
        last_o          = 1'b0;
        tmr_d.line_prev = line_in;
        case (tmr_q.state)
            RX_IDLE: begin
                if (tmr_q.line_prev && !line_in) begin
                    tmr_d.state    = RX_CAPTURE;
                    tmr_d.wait_cnt = {1'b0, slot_div >> 1} + {1'b0, slot_div} - CNT_ONE;
                    tmr_d.slot     = SLOT_W'(4);
                end
            end
            default: begin
                if (tmr_q.wait_cnt == '0) begin
                    take_o         = 1'b1;
                    tmr_d.wait_cnt = {1'b0, slot_div} - CNT_ONE;
                    if (tmr_q.slot == SLOT_W'(SLOTS - 1)) begin
                        last_o      = 1'b1;
                        tmr_d.state = RX_IDLE;
                    end else begin
                        tmr_d.slot = tmr_q.slot + 1'b1;
                    end
                end else begin
                    tmr_d.wait_cnt = tmr_q.wait_cnt - CNT_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= TMR_RST;
        else     tmr_q <= tmr_d;
    end
endmodule

// File: rtl/bmc_slot_shift.sv
module bmc_slot_shift #(
    parameter int DEPTH = 59
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  logic             line_in,
    output logic [DEPTH-1:0] held_o
);
    logic [DEPTH-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (take_i) held_d = {line_in, held_q[DEPTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= held_d;
    end

    assign held_o = held_q;
endmodule

// File: rtl/bmc_word_check.sv
module bmc_word_check
    import bmc_rx_pkg::*;
(
    input  logic [SLOTS-1:0] slots_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [1:0]       width_sel,
    output logic [AUD_W-1:0] sample_o,
    output logic             invalid_o,
    output logic             pre_ok_o,
    output logic             par_ok_o
);
    localparam int CUT16 = AUD_W - 16;
    localparam int CUT20 = AUD_W - 20;

    logic [BITS-1:AUD_LSB]  word;
    logic [AUD_W-1:0]       audio;
    logic [7:0]             pre_exp;

    for (genvar gi = AUD_LSB; gi < BITS; gi++) begin : g_bit
        assign word[gi] = slots_i[2*gi] ^ slots_i[2*gi+1];
    end

    assign audio     = word[AUD_LSB+AUD_W-1:AUD_LSB];
    assign invalid_o = word[INV_BIT];
    assign par_ok_o  = (^word[PAR_BIT-1:AUD_LSB]) == word[PAR_BIT];

    always_comb begin
        if (pos_i == '0)   pre_exp = PRE_BLOCK;
        else if (pos_i[0]) pre_exp = PRE_ODD;
        else               pre_exp = PRE_EVEN;
    end
    assign pre_ok_o = slots_i[7:0] == pre_exp;

    always_comb begin
        case (width_sel)
            2'd0:    sample_o = audio >> CUT16;
            2'd1:    sample_o = audio >> CUT20;
            default: sample_o = audio;
        endcase
    end
endmodule

// File: rtl/bmc_subframe_rx.sv
module bmc_subframe_rx
    import bmc_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic [DIV_W-1:0] slot_div,
    input  logic [1:0]       width_sel,
    output logic [AUD_W-1:0] sample_o,
    output logic             sample_stb_o,
    output logic             pre_err_o,
    output logic             par_err_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [AUD_W-1:0] sample;
        logic             stb;
        logic             pre_err;
        logic             par_err;
    } out_t;

    logic              take, last;
    logic [HELD_W-1:0] held;
    logic [SLOTS-1:0]  full;
    logic [AUD_W-1:0]  trunc;
    logic              invalid, pre_ok, par_ok;
    out_t              out_d, out_q;

    bmc_slot_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .slot_div (slot_div),
        .take_o   (take),
        .last_o   (last)
    );

    bmc_slot_shift #(.DEPTH(HELD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .line_in (line_in),
        .held_o  (held)
    );

    assign full = {line_in, held, LEAD_SLOTS};

    bmc_word_check u_check (
        .slots_i   (full),
        .pos_i     (out_q.pos),
        .width_sel (width_sel),
        .sample_o  (trunc),
        .invalid_o (invalid),
        .pre_ok_o  (pre_ok),
        .par_ok_o  (par_ok)
    );

    always_comb begin
        out_d         = out_q;
        out_d.stb     = 1'b0;
        out_d.pre_err = 1'b0;
        out_d.par_err = 1'b0;
        if (last) begin
            out_d.stb     = !invalid;
            out_d.pre_err = !pre_ok;
            out_d.par_err = !par_ok;
            if (!invalid) out_d.sample = trunc;
            out_d.pos = (out_q.pos == POS_W'(BLOCK_LEN - 1)) ? '0 : out_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign sample_o     = out_q.sample;
    assign sample_stb_o = out_q.stb;
    assign pre_err_o    = out_q.pre_err;
    assign par_err_o    = out_q.par_err;
endmodule

// File: rtl/bmc_subframe_rx_chk.sv
module bmc_subframe_rx_chk
    import bmc_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       width_sel,
    input logic [AUD_W-1:0] sample_o,
    input logic             sample_stb_o,
    input logic             pre_err_o,
    input logic             par_err_o
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sample_stb_o && !pre_err_o && !par_err_o && sample_o == '0));

    a_r4_stb_single: assert property (@(posedge clk) disable iff (rst)
        sample_stb_o |=> !sample_stb_o);

    a_r6_pre_single: assert property (@(posedge clk) disable iff (rst)
        pre_err_o |=> !pre_err_o);

    a_r7_par_single: assert property (@(posedge clk) disable iff (rst)
        par_err_o |=> !par_err_o);

    a_r5_width16: assert property (@(posedge clk) disable iff (rst)
        (sample_stb_o && $past(width_sel) == 2'd0) |-> sample_o[AUD_W-1:16] == '0);

    a_r5_width20: assert property (@(posedge clk) disable iff (rst)
        (sample_stb_o && $past(width_sel) == 2'd1) |-> sample_o[AUD_W-1:20] == '0);
endmodule

bind bmc_subframe_rx bmc_subframe_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .width_sel    (width_sel),
    .sample_o     (sample_o),
    .sample_stb_o (sample_stb_o),
    .pre_err_o    (pre_err_o),
    .par_err_o    (par_err_o)
);

// File: tb/sim_bmc_subframe_rx.sv
`timescale 1ns/1ps
module sim_bmc_subframe_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic [7:0]  div = 8'd4;
    logic [1:0]  wsel = 2'd2;
    logic [23:0] sample;
    logic        stb, perr, parerr;

    always #10 clk = ~clk;

    bmc_subframe_rx #(.DIV_W(8)) u0 (
        .clk          (clk),
        .rst          (rst),
        .line_in      (line),
        .slot_div     (div),
        .width_sel    (wsel),
        .sample_o     (sample),
        .sample_stb_o (stb),
        .pre_err_o    (perr),
        .par_err_o    (parerr)
    );

    int tests = 0, fails = 0, cyc = 0, pos = 0;
    int n_stb = 0, n_pre = 0, n_par = 0, stb_cyc = 0;
    logic [23:0] got = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (stb) begin n_stb = n_stb + 1; got = sample; stb_cyc = cyc; end
        if (perr)   n_pre = n_pre + 1;
        if (parerr) n_par = n_par + 1;
    end

    // fields: [27:26] width select, [25] invalid, [24] corrupt parity, [23:0] audio
    localparam logic [27:0] VEC [8] = '{
        {2'd2, 1'b0, 1'b0, 24'h123456},
        {2'd0, 1'b0, 1'b0, 24'hABCDEF},
        {2'd1, 1'b0, 1'b0, 24'hFEDCBA},
        {2'd2, 1'b0, 1'b0, 24'h000001},
        {2'd2, 1'b0, 1'b0, 24'h800000},
        {2'd2, 1'b1, 1'b0, 24'h555555},
        {2'd2, 1'b0, 1'b1, 24'h0F0F0F},
        {2'd3, 1'b0, 1'b0, 24'hFFFFFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pre_for(input int p);
        if (p == 0) return 8'h17;
        if (p % 2 == 1) return 8'h27;
        return 8'h47;
    endfunction

    function automatic logic [31:0] mk_word(input logic [23:0] s, input logic inv, input logic bad);
        logic [31:0] w;
        w = '0;
        w[27:4] = s;
        w[28] = inv;
        w[31] = (^w[30:4]) ^ bad;
        return w;
    endfunction

    function automatic logic [23:0] exp_trunc(input logic [23:0] s, input logic [1:0] ws);
        if (ws == 2'd0) return s >> 8;
        if (ws == 2'd1) return s >> 4;
        return s;
    endfunction

    task automatic send_sub(input logic [31:0] w, input logic [7:0] pre, output int fall_c);
        logic [63:0] s;
        logic lvl;
        s = '0;
        s[7:0] = pre;
        lvl = pre[7];
        fall_c = 0;
        for (int i = 4; i < 32; i++) begin
            s[2*i]   = ~lvl;
            s[2*i+1] = ~lvl ^ w[i];
            lvl = s[2*i+1];
        end
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            line = s[k];
            if (k == 3) fall_c = cyc;
            repeat (int'(div) - 1) @(negedge clk);
        end
    endtask

    task automatic run_sub(input logic [23:0] smp, input logic inv, input logic bad,
                           input logic [1:0] ws, input logic [7:0] pre, input logic exp_pre,
                           input string tag);
        int s0, p0, r0, fc;
        wsel = ws;
        s0 = n_stb; p0 = n_pre; r0 = n_par;
        send_sub(mk_word(smp, inv, bad), pre, fc);
        @(negedge clk); #1;
        chk({tag, " R4 strobe count"}, 32'(n_stb - s0), inv ? 32'd0 : 32'd1);
        chk({tag, " R6 preamble flag"}, 32'(n_pre - p0), 32'(exp_pre));
        chk({tag, " R7 parity flag"}, 32'(n_par - r0), 32'(bad));
        if (!inv) begin
            chk({tag, " R3 R5 sample"}, 32'(got), 32'(exp_trunc(smp, ws)));
            chk({tag, " R2 strobe cycle"}, 32'(stb_cyc), 32'(fc + 1 + int'(div) / 2 + 60 * int'(div)));
        end
        pos = (pos == 383) ? 0 : pos + 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int fc, s0, p0;
        repeat (5) @(negedge clk);
        chk("R1 reset outputs", {5'd0, stb, perr, parerr, sample}, 32'd0);

        // R1: subframe sent under reset is ignored
        send_sub(mk_word(24'h777777, 1'b0, 1'b0), 8'h17, fc);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 line ignored in reset", 32'(n_stb + n_pre + n_par), 32'd0);

        // table walk, positions 0..7
        for (int v = 0; v < 8; v++) begin
            run_sub(VEC[v][23:0], VEC[v][25], VEC[v][24], VEC[v][27:26], pre_for(pos), 1'b0, "vec");
        end

        // R6 R8: wrong preamble still decodes, next one recovers
        run_sub(24'h13579B, 1'b0, 1'b0, 2'd2, 8'h27, 1'b1, "R8 bad preamble");
        run_sub(24'h2468AC, 1'b0, 1'b0, 2'd2, pre_for(pos), 1'b0, "R8 recovery");

        // R1: reset in the middle of a capture
        @(negedge clk); line = 1'b0;
        repeat (50) @(negedge clk);
        line = 1'b1; rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0; pos = 0;
        repeat (4) @(negedge clk);
        run_sub(24'h00C0DE, 1'b0, 1'b0, 2'd2, 8'h17, 1'b0, "R1 after mid reset");

        // R6: walk a whole block and wrap
        s0 = n_stb; p0 = n_pre;
        wsel = 2'd2;
        for (int k = 1; k < 384; k++) begin
            send_sub(mk_word(24'(k * 4099), 1'b0, 1'b0), pre_for(pos), fc);
            pos = (pos == 383) ? 0 : pos + 1;
        end
        @(negedge clk); #1;
        chk("R6 block strobes", 32'(n_stb - s0), 32'd383);
        chk("R6 block no preamble error", 32'(n_pre - p0), 32'd0);
        run_sub(24'h0A0B0C, 1'b0, 1'b0, 2'd2, 8'h17, 1'b0, "R6 wrap to block start");
        run_sub(24'h0D0E0F, 1'b0, 1'b0, 2'd2, 8'h17, 1'b1, "R6 block code misplaced");

        // R9: other divisors
        rst = 1'b1; div = 8'd5;
        repeat (4) @(negedge clk);
        rst = 1'b0; pos = 0;
        repeat (4) @(negedge clk);
        run_sub(24'h31415F, 1'b0, 1'b0, 2'd2, 8'h17, 1'b0, "R9 div5");
        run_sub(24'h27182A, 1'b0, 1'b0, 2'd0, 8'h27, 1'b0, "R9 div5");
        rst = 1'b1; div = 8'd8;
        repeat (4) @(negedge clk);
        rst = 1'b0; pos = 0;
        repeat (4) @(negedge clk);
        run_sub(24'hC3A5E1, 1'b0, 1'b0, 2'd1, 8'h17, 1'b0, "R9 div8");
        run_sub(24'h5A5A5A, 1'b0, 1'b1, 2'd2, 8'h27, 1'b0, "R9 div8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule